// File: doc/BRIEF.md
# Descriptor Quad Load/Store Unit

This unit carries out the two small data-movement commands of a descriptor-driven DMA channel: storing the 32-bit data word held inside a descriptor out to a target address, and loading a value from a target address back into that descriptor word. A transfer moves 1, 2 or 4 bytes. The size comes from the low three bits of the command's request count. The target address is rounded down to a multiple of that size.

The target can be plain memory or a device register. The memory-side port reports two attributes for the current address: whether it is a device register and whether it is writable memory. Device registers see the bytes in the opposite order from memory. A store to read-only memory is dropped. A load is skipped when the descriptor itself cannot be written.

The channel sequencer pulses `start` with the command fields valid. The unit then runs one memory-side access and, for a load, one write into the descriptor word. It finishes with a single `done` pulse, and `branchEval` flags that the sequencer must evaluate the branch condition next. Fetching the descriptor and completing it are handled outside this unit.

Top module: `quad_xfer_unit`

## Requirements
- R1: The transfer size comes from the 3-bit request count alone. Values 4 to 7 give 4 bytes, 2 or 3 give 2 bytes, and 0 or 1 give 1 byte. `memSize` encodes it as 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes.
- R2: `memAddr` equals the command address with its low (size-1) bits cleared.
- R3: A store to writable memory drives `memWrite` high. `memWdata` carries the descriptor data word's low `size` bytes in unchanged lane order: descriptor byte 8 goes on `memWdata[7:0]`. All lanes above the size are zero.
- R4: A store whose target is memory marked not writable makes no memory request. A store to a device register is always issued.
- R5: When `memIsMmio` is high, the bytes are mirrored within the transfer size. Lane i carries byte size-1-i. This applies to the store data on `memWdata` and to the load data on `descWdata`.
- R6: A load with a writable descriptor issues a read (`memWrite` low). Afterwards it pulses `descWe` exactly once. `descWdata` holds the returned bytes in the low `size` lanes, zero above. `descByteEn` has its low `size` bits set.
- R7: A load with a non-writable descriptor issues no memory request and no `descWe`.
- R8: `done` is a one-cycle pulse. For a store, it comes in the cycle after the cycle in which `memAck` is accepted. For a load, it comes in the cycle after `descWe`. When a transfer is skipped, `done` comes two cycles after the `start` cycle. After reset, `done`, `memReq` and `descWe` are low.
- R9: `branchEval` is high together with `done` exactly when either bit of `branchMode` was set at `start`.
- R10: A `start` pulse while a command is in progress is ignored. It causes no extra `done` and no change to the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a command; fields sampled this cycle |
| isStore | input | 1 | 1 = store data word to target, 0 = load into data word |
| reqCountLow | input | 3 | Low bits of the request count |
| cmdAddr | input | ADDR_W | Target address from the descriptor |
| branchMode | input | 2 | Branch-mode bits of the command |
| descWritable | input | 1 | Descriptor storage is writable |
| descDataIn | input | 32 | Descriptor data word (byte 8 in bits 7:0) |
| memReq | output | 1 | Memory-side request, held until acknowledged |
| memWrite | output | 1 | Request is a write |
| memAddr | output | ADDR_W | Aligned target address |
| memSize | output | 2 | Size code: 0=1B, 1=2B, 2=4B |
| memWdata | output | 32 | Store data, right-aligned |
| memRdata | input | 32 | Load data, right-aligned, valid with memAck |
| memAck | input | 1 | Access completes this cycle |
| memIsMmio | input | 1 | Current address is a device register |
| memWritable | input | 1 | Current address is writable memory |
| descWe | output | 1 | Write strobe into descriptor data word |
| descByteEn | output | 4 | Byte enables for the descriptor write |
| descWdata | output | 32 | Data for the descriptor word |
| done | output | 1 | Command finished (one cycle) |
| branchEval | output | 1 | Branch evaluation required, valid with done |

## Verification
A wrong size or alignment latched at start shows up on `memSize`/`memAddr` in the first request cycle. A wrong byte-order decision only appears in the data lanes, so every size is driven against each kind of target. A control state that fails to leave the access phase, or leaves it early, moves or removes the `done` pulse relative to `memAck` and `descWe`. The bench measures that placement to the cycle. A `start` accepted while busy would show as a second request or a second `done` within a few cycles, and the bench watches the whole window.

// File: rtl/qxu_pkg.sv
package qxu_pkg;

  localparam int DATA_BYTES = 4;
  localparam int DATA_W     = DATA_BYTES * 8;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_DESC   = 2'd2,
    ST_FINISH = 2'd3
  } qxuState_e;

  // strobes from the control FSM into the datapath
  typedef struct packed {
    logic capture;  // latch command fields
    logic latchRd;  // latch returned load data
    logic finish;   // final cycle of the command
  } qxuStrobe_t;

  // size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes
  function automatic logic [1:0] sizeCode(input logic [2:0] cnt);
    if (cnt[2])      return 2'd2;
    else if (cnt[1]) return 2'd1;
    else             return 2'd0;
  endfunction

  function automatic logic [DATA_BYTES-1:0] laneMask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 4'b0001;
      2'd1:    return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  // mirror the bytes inside the active size, zero elsewhere
  function automatic logic [DATA_W-1:0] mirrorBytes(input logic [DATA_W-1:0] x,
                                                    input logic [1:0] sz);
    logic [DATA_W-1:0] r;
    int n;
    r = '0;
    n = 1 << sz;
    for (int i = 0; i < DATA_BYTES; i++) begin
      if (i < n) r[8*i +: 8] = x[8*(n-1-i) +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/qxu_datapath.sv
module qxu_datapath
  import qxu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  qxuStrobe_t        strobe,
  input  logic [2:0]        reqCountLow,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [1:0]        branchMode,
  input  logic [DATA_W-1:0] descDataIn,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memIsMmio,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        memSize,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] descWdata,
  output logic [DATA_BYTES-1:0] descByteEn,
  output logic              branchEval
);

  logic [1:0]            sizeNew;
  logic [DATA_BYTES-1:0] laneNew;
  logic [ADDR_W-1:0]     offNew;
  logic [DATA_W-1:0]     bitMaskNew;

  logic [1:0]            sizeQ;
  logic [ADDR_W-1:0]     addrQ;
  logic [DATA_W-1:0]     srcQ;
  logic [DATA_W-1:0]     rdQ;
  logic                  branchQ;
  logic [DATA_BYTES-1:0] laneQ;
  logic [DATA_W-1:0]     bitMaskQ;
  logic [DATA_W-1:0]     rdMasked;

  always_comb begin
    sizeNew = sizeCode(reqCountLow);
    laneNew = laneMask(sizeNew);
    offNew  = ADDR_W'((3'd1 << sizeNew) - 3'd1);
  end

  assign laneQ = laneMask(sizeQ);

  // per-lane byte masks for the new and the held size
  for (genvar b = 0; b < DATA_BYTES; b++) begin : g_lane
    assign bitMaskNew[8*b +: 8] = {8{laneNew[b]}};
    assign bitMaskQ[8*b +: 8]   = {8{laneQ[b]}};
  end

  assign rdMasked = memRdata & bitMaskQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sizeQ   <= '0;
      addrQ   <= '0;
      srcQ    <= '0;
      rdQ     <= '0;
      branchQ <= 1'b0;
    end else begin
      if (strobe.capture) begin
        sizeQ   <= sizeNew;
        addrQ   <= cmdAddr & ~offNew;
        srcQ    <= descDataIn & bitMaskNew;
        branchQ <= |branchMode;
      end
      if (strobe.latchRd) begin
        rdQ <= memIsMmio ? mirrorBytes(rdMasked, sizeQ) : rdMasked;
      end
    end
  end

  assign memAddr    = addrQ;
  assign memSize    = sizeQ;
  assign memWdata   = memIsMmio ? mirrorBytes(srcQ, sizeQ) : srcQ;
  assign descWdata  = rdQ;
  assign descByteEn = laneQ;
  assign branchEval = strobe.finish & branchQ;

  // R1
  size_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    memSize != 2'd3);

  // R2
  addr_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memAddr & ADDR_W'((3'd1 << memSize) - 3'd1)) == '0);

  // R9
  branch_only_at_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    branchEval |-> strobe.finish);

endmodule

// File: rtl/qxu_ctrl.sv
module qxu_ctrl
  import qxu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       isStore,
  input  logic       descWritable,
  input  logic       memAck,
  input  logic       memIsMmio,
  input  logic       memWritable,
  output qxuStrobe_t strobe,
  output logic       memReq,
  output logic       memWrite,
  output logic       descWe,
  output logic       done
);

  qxuState_e state, stateNext;
  logic      storeQ;
  logic      loadOkQ;
  logic      storePermit;

  assign storePermit = memIsMmio | memWritable;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    memReq    = 1'b0;
    memWrite  = 1'b0;
    descWe    = 1'b0;
    done      = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.capture = 1'b1;
          stateNext      = ST_ACCESS;
        end
      end
      ST_ACCESS: begin
        if (storeQ) begin
          memReq   = storePermit;
          memWrite = storePermit;
          if (!storePermit || memAck) stateNext = ST_FINISH;
        end else if (loadOkQ) begin
          memReq = 1'b1;
          if (memAck) begin
            strobe.latchRd = 1'b1;
            stateNext      = ST_DESC;
          end
        end else begin
          stateNext = ST_FINISH;
        end
      end
      ST_DESC: begin
        descWe    = 1'b1;
        stateNext = ST_FINISH;
      end
      default: begin
        done          = 1'b1;
        strobe.finish = 1'b1;
        stateNext     = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      storeQ  <= 1'b0;
      loadOkQ <= 1'b0;
    end else begin
      state <= stateNext;
      if (strobe.capture) begin
        storeQ  <= isStore;
        loadOkQ <= descWritable;
      end
    end
  end

  // R4
  store_permit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWrite) |-> (memIsMmio || memWritable));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6
  desc_then_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    descWe |=> done);

  // R10
  busy_no_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq || descWe || done) |-> !strobe.capture);

  // R7
  load_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWrite) |-> loadOkQ);

endmodule

// File: rtl/quad_xfer_unit.sv
module quad_xfer_unit
  import qxu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              isStore,
  input  logic [2:0]        reqCountLow,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [1:0]        branchMode,
  input  logic              descWritable,
  input  logic [31:0]       descDataIn,
  output logic              memReq,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        memSize,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memAck,
  input  logic              memIsMmio,
  input  logic              memWritable,
  output logic              descWe,
  output logic [3:0]        descByteEn,
  output logic [31:0]       descWdata,
  output logic              done,
  output logic              branchEval
);

  qxuStrobe_t strobe;

  qxu_ctrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .isStore      (isStore),
    .descWritable (descWritable),
    .memAck       (memAck),
    .memIsMmio    (memIsMmio),
    .memWritable  (memWritable),
    .strobe       (strobe),
    .memReq       (memReq),
    .memWrite     (memWrite),
    .descWe       (descWe),
    .done         (done)
  );

  qxu_datapath #(.ADDR_W(ADDR_W)) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqCountLow (reqCountLow),
    .cmdAddr     (cmdAddr),
    .branchMode  (branchMode),
    .descDataIn  (descDataIn),
    .memRdata    (memRdata),
    .memIsMmio   (memIsMmio),
    .memAddr     (memAddr),
    .memSize     (memSize),
    .memWdata    (memWdata),
    .descWdata   (descWdata),
    .descByteEn  (descByteEn),
    .branchEval  (branchEval)
  );

endmodule

// File: tb/test_quad_xfer_unit.sv
module test_quad_xfer_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        isStore = 1'b0;
  logic [2:0]  reqCountLow = '0;
  logic [31:0] cmdAddr = '0;
  logic [1:0]  branchMode = '0;
  logic        descWritable = 1'b0;
  logic [31:0] descDataIn = '0;
  logic        memReq, memWrite;
  logic [31:0] memAddr;
  logic [1:0]  memSize;
  logic [31:0] memWdata;
  logic [31:0] memRdata = '0;
  logic        memAck = 1'b0;
  logic        memIsMmio, memWritable;
  logic        descWe;
  logic [3:0]  descByteEn;
  logic [31:0] descWdata;
  logic        done, branchEval;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // target map: F... device registers, E... read-only memory, rest writable
  assign memIsMmio   = (memAddr[31:28] == 4'hF);
  assign memWritable = (memAddr[31:28] != 4'hF) && (memAddr[31:28] != 4'hE);

  quad_xfer_unit i_quad_xfer_unit (
    .clk(clk), .rstN(rstN), .start(start), .isStore(isStore),
    .reqCountLow(reqCountLow), .cmdAddr(cmdAddr), .branchMode(branchMode),
    .descWritable(descWritable), .descDataIn(descDataIn),
    .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr), .memSize(memSize),
    .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck),
    .memIsMmio(memIsMmio), .memWritable(memWritable),
    .descWe(descWe), .descByteEn(descByteEn), .descWdata(descWdata),
    .done(done), .branchEval(branchEval)
  );

  function automatic logic [31:0] rdModel(input logic [31:0] a);
    return {a[7:0] ^ 8'h5A, a[7:0] + 8'd3, ~a[7:0], a[15:8] ^ a[7:0]};
  endfunction

  function automatic int expBytes(input logic [2:0] rc);
    if (rc >= 3'd4) return 4;
    if (rc >= 3'd2) return 2;
    return 1;
  endfunction

  function automatic logic [31:0] keepLow(input logic [31:0] x, input int n);
    if (n == 1) return {24'h0, x[7:0]};
    if (n == 2) return {16'h0, x[15:0]};
    return x;
  endfunction

  function automatic logic [31:0] swapN(input logic [31:0] x, input int n);
    if (n == 1) return {24'h0, x[7:0]};
    if (n == 2) return {16'h0, x[7:0], x[15:8]};
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runOp(input bit st, input logic [2:0] rc, input logic [31:0] addr,
                       input logic [1:0] bm, input bit dw, input logic [31:0] dd,
                       input int lat0, input bit poke);
    int n = expBytes(rc);
    logic [31:0] aAl = addr & ~(32'(n) - 32'd1);
    bit mmio = (aAl[31:28] == 4'hF);
    bit ro   = (aAl[31:28] == 4'hE);
    bit expReq = st ? (mmio || !ro) : dw;
    bit expWe  = !st && dw;
    logic [31:0] expW = mmio ? swapN(dd, n) : keepLow(dd, n);
    logic [31:0] expD = mmio ? swapN(rdModel(aAl), n) : keepLow(rdModel(aAl), n);
    logic [3:0]  expBe = (n == 1) ? 4'b0001 : (n == 2) ? 4'b0011 : 4'b1111;
    bit reqSeen = 0, wrSeen = 0;
    logic [31:0] reqAddr = '0, reqWd = '0, weData = '0;
    logic [1:0]  reqSz = '0;
    logic [3:0]  weBe = '0;
    int weCnt = 0, doneCnt = 0, cyc = 0, ackCyc = -1, weCyc = -1, doneCyc = -1;
    int lat = lat0;
    bit bEval = 0;

    @(negedge clk);
    start = 1'b1; isStore = st; reqCountLow = rc; cmdAddr = addr;
    branchMode = bm; descWritable = dw; descDataIn = dd;
    for (int k = 0; k < 14; k++) begin
      @(negedge clk);
      cyc++;
      if (done) begin doneCnt++; doneCyc = cyc; bEval = branchEval; end
      if (memReq && !reqSeen) begin
        reqSeen = 1; reqAddr = memAddr; reqSz = memSize;
        wrSeen = memWrite; reqWd = memWdata;
      end
      if (descWe) begin weCnt++; weCyc = cyc; weData = descWdata; weBe = descByteEn; end
      // responder
      if (memAck) memAck = 1'b0;
      else if (memReq) begin
        if (lat == 0) begin memAck = 1'b1; memRdata = rdModel(memAddr); ackCyc = cyc; end
        else lat--;
      end
      // drive start / poke
      if (k == 0) begin
        start = poke; isStore = !st; cmdAddr = 32'hDEAD_BEEF;
        reqCountLow = 3'd7; descWritable = !dw;
      end else start = 1'b0;
    end

    if (expReq) begin
      chk(reqSeen, st ? "R4 request issued" : "R6 read issued", 32'(reqSeen), 32'd1);
      chk(reqAddr == aAl, "R2 aligned address", reqAddr, aAl);
      chk(reqSz == ((n == 4) ? 2'd2 : (n == 2) ? 2'd1 : 2'd0), "R1 size code",
          32'(reqSz), 32'(n));
      chk(wrSeen == st, st ? "R3 write flag" : "R6 read flag", 32'(wrSeen), 32'(st));
      if (st) chk(reqWd == expW, mmio ? "R5 mirrored store data" : "R3 store data",
                  reqWd, expW);
    end else begin
      chk(!reqSeen, st ? "R4 store suppressed" : "R7 load suppressed",
          32'(reqSeen), 32'd0);
    end
    chk(weCnt == (expWe ? 1 : 0), expWe ? "R6 one descriptor write" : "R7 no descriptor write",
        32'(weCnt), 32'(expWe));
    if (expWe) begin
      chk(weData == expD, mmio ? "R5 mirrored load data" : "R6 load data", weData, expD);
      chk(weBe == expBe, "R6 byte enables", 32'(weBe), 32'(expBe));
    end
    chk(doneCnt == 1, poke ? "R10 single done despite second start" : "R8 single done",
        32'(doneCnt), 32'd1);
    if (expReq && st)
      chk(doneCyc == ackCyc + 1, "R8 done after store ack", 32'(doneCyc), 32'(ackCyc + 1));
    else if (expWe) begin
      chk(weCyc == ackCyc + 1, "R6 descriptor write after ack", 32'(weCyc), 32'(ackCyc + 1));
      chk(doneCyc == weCyc + 1, "R8 done after descriptor write", 32'(doneCyc), 32'(weCyc + 1));
    end else
      chk(doneCyc == 2, "R8 done for skipped transfer", 32'(doneCyc), 32'd2);
    chk(bEval == (|bm), "R9 branch evaluation flag", 32'(bEval), 32'(|bm));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !memReq && !descWe, "R8 reset state quiet",
        {29'h0, done, memReq, descWe}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!done && !memReq && !descWe, "R8 idle after reset",
        {29'h0, done, memReq, descWe}, 32'h0);
    for (int st = 0; st < 2; st++)
      for (int rc = 0; rc < 8; rc++)
        for (int rg = 0; rg < 3; rg++)
          for (int dw = 0; dw < 2; dw++) begin
            int k = ((st * 8 + rc) * 3 + rg) * 2 + dw;
            logic [31:0] base = (rg == 0) ? 32'h1000_0000 :
                                (rg == 1) ? 32'hE000_0000 : 32'hF000_0000;
            logic [31:0] a = base | (32'(k) * 32'h0000_0104) | 32'(k % 4);
            logic [31:0] d = 32'hA1B2_C3D4 ^ (32'(k) * 32'h0101_0101);
            runOp(st[0], rc[2:0], a, k[1:0], dw[0], d, k % 3, (k % 5) == 1);
          end
    // R1: upper count bits are not visible; a count of 0 gives a single byte
    runOp(1'b1, 3'd0, 32'h2000_0007, 2'b10, 1'b1, 32'h1122_3344, 0, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule